// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small multicycle load/store processor. A micro-program counter addresses a control store built into the block. Every cycle the addressed microinstruction drives the datapath. Each microinstruction has two parts. One part is the datapath control: some fields are horizontal, with one bit per control line, and others are vertical codes that a decoder expands. The other part is a sequencing code that picks the next micro-address.

Only three next-address choices exist: go back to the fetch routine at address zero, step to the next address, or jump through a dispatch table. The dispatch table is indexed by the instruction opcode. Any opcode that has no routine is sent to an illegal-instruction routine. Memory microinstructions wait for a memory-ready flag. While the flag is low, the micro-program counter does not move and the datapath write strobes are held off.

Top module: `mseq_top`

## Requirements
- R1: While reset is high at a clock edge, the micro-program counter `upc` becomes 0 on that edge. After reset is released, the first word executed is the fetch word.
- R2: Word 0 (fetch) asserts `mem_rd`, `mem_iaddr`, `ir_we`, `pc_we` and the ADD ALU select. Its successor is word 1.
- R3: Word 1 (decode) asserts only `opr_we`. Its successor is read from the dispatch table at the current `opcode`. The table entries are: opcode 0 (register op) goes to 2, 1 (load) to 4, 2 (store) to 7, 3 (or-immediate) to 9, and 4 (branch-equal) to 11.
- R4: The routines run in this order and then return to 0. Register op: 2 (`res_we`, FUNC) then 3. Load: 4 (`res_we`, ADD), 5 (`mem_rd`), 6. Store: 7 (`res_we`, ADD) then 8 (`mem_wr`). Or-immediate: 9 (`res_we`, OR) then 10. Branch-equal: 11 (`br_en`, SUB).
- R5: Opcodes 5, 6 and 7 dispatch to word 12. Word 12 asserts `epc_we` and `pc_we`, and then returns to 0.
- R6: The write-back destination code is decoded as follows. rd gives `reg_we` and `reg_dst_rd` (word 3). rt gives `reg_we` only (word 10). Memory gives `reg_we` and `wb_mem` (word 6). No destination gives none of these three signals.
- R7: The ALU code is decoded to the one-hot `alu_sel`, with bit0 ADD, bit1 SUB, bit2 OR and bit3 FUNC. Words that use no ALU drive `alu_sel` to 0.
- R8: In a memory word (`mem_rd` or `mem_wr` high), `mem_ready` low holds `upc` at the next edge and keeps the memory request asserted.
- R9: During such a wait cycle the strobes `ir_we`, `pc_we`, `opr_we`, `res_we`, `br_en`, `epc_we` and `reg_we` are all low. They assert in the cycle in which `mem_ready` is high.
- R10: `mem_rd` and `mem_wr` are never high together. `mem_iaddr` is high only together with `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 3 | Opcode of the current instruction |
| mem_ready | input | 1 | Memory has completed the current access |
| upc | output | 4 | Micro-program counter |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_iaddr | output | 1 | Memory address taken from the PC (instruction fetch) |
| ir_we | output | 1 | Instruction register write |
| pc_we | output | 1 | PC write |
| opr_we | output | 1 | Operand registers write |
| res_we | output | 1 | ALU result register write |
| br_en | output | 1 | Conditional branch enable |
| epc_we | output | 1 | Exception PC write |
| reg_we | output | 1 | Register file write |
| reg_dst_rd | output | 1 | Register file destination is rd (else rt) |
| wb_mem | output | 1 | Register write data comes from memory |
| alu_sel | output | 4 | One-hot ALU operation select |

## Verification
All control outputs are combinational from `upc`, so they belong to the same cycle as the micro-address that produces them. Each new micro-address appears one edge after the word that selected it, or later by one edge for each cycle in which `mem_ready` was low. The bench applies stimulus on the falling edge and checks `upc` together with every control output shortly afterwards. It walks all eight opcodes with zero, one and two wait cycles at each memory word. It builds the expected micro-address path and control pattern from the routine lists in the requirements.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int OP_W    = 3;
    localparam int UA_W    = 4;
    localparam int NUM_OPS = 1 << OP_W;
    localparam int ALU_N   = 4;

    typedef logic [UA_W-1:0] uaddr_t;
    typedef logic [OP_W-1:0] opc_t;

    typedef enum logic [1:0] {SEQ_FETCH, SEQ_NEXT, SEQ_DISPATCH} seq_e;
    typedef enum logic [1:0] {MEM_IDLE, MEM_IFETCH, MEM_LOAD, MEM_STORE} mem_e;
    typedef enum logic [1:0] {DST_NONE, DST_RT, DST_RD, DST_MEM} dst_e;
    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR, ALU_FUNC} alu_e;

    typedef struct packed {
        logic ir_we;
        logic pc_we;
        logic opr_we;
        logic res_we;
        logic br_en;
        logic epc_we;
    } strobe_t;

    typedef struct packed {
        seq_e    seq;
        mem_e    mem;
        dst_e    dst;
        logic    alu_en;
        alu_e    alu;
        strobe_t stb;
    } uword_t;

    typedef struct packed {
        logic             mem_rd;
        logic             mem_wr;
        logic             mem_iaddr;
        strobe_t          stb;
        logic             reg_we;
        logic             reg_dst_rd;
        logic             wb_mem;
        logic [ALU_N-1:0] alu_sel;
    } ctrl_t;

    localparam uaddr_t UA_FETCH  = 4'd0;
    localparam uaddr_t UA_DECODE = 4'd1;
    localparam uaddr_t UA_RTYPE  = 4'd2;
    localparam uaddr_t UA_LOAD   = 4'd4;
    localparam uaddr_t UA_STORE  = 4'd7;
    localparam uaddr_t UA_ORI    = 4'd9;
    localparam uaddr_t UA_BEQ    = 4'd11;
    localparam uaddr_t UA_ILLEGAL= 4'd12;

    function automatic uaddr_t dispatch_entry(int op);
        case (op)
            0:       return UA_RTYPE;
            1:       return UA_LOAD;
            2:       return UA_STORE;
            3:       return UA_ORI;
            4:       return UA_BEQ;
            default: return UA_ILLEGAL;
        endcase
    endfunction
endpackage

// File: rtl/mseq_store.sv
module mseq_store
    import mseq_pkg::*;
(
    input  uaddr_t addr,
    output uword_t word
);
    always_comb begin
        word = '0;
        word.seq = SEQ_FETCH;
        case (addr)
            4'd0: begin
                word.seq = SEQ_NEXT;   word.mem = MEM_IFETCH;
                word.alu_en = 1'b1;    word.alu = ALU_ADD;
                word.stb.ir_we = 1'b1; word.stb.pc_we = 1'b1;
            end
            4'd1: begin
                word.seq = SEQ_DISPATCH; word.stb.opr_we = 1'b1;
            end
            4'd2: begin
                word.seq = SEQ_NEXT; word.alu_en = 1'b1; word.alu = ALU_FUNC;
                word.stb.res_we = 1'b1;
            end
            4'd3: word.dst = DST_RD;
            4'd4: begin
                word.seq = SEQ_NEXT; word.alu_en = 1'b1; word.alu = ALU_ADD;
                word.stb.res_we = 1'b1;
            end
            4'd5: begin
                word.seq = SEQ_NEXT; word.mem = MEM_LOAD;
            end
            4'd6: word.dst = DST_MEM;
            4'd7: begin
                word.seq = SEQ_NEXT; word.alu_en = 1'b1; word.alu = ALU_ADD;
                word.stb.res_we = 1'b1;
            end
            4'd8: word.mem = MEM_STORE;
            4'd9: begin
                word.seq = SEQ_NEXT; word.alu_en = 1'b1; word.alu = ALU_OR;
                word.stb.res_we = 1'b1;
            end
            4'd10: word.dst = DST_RT;
            4'd11: begin
                word.alu_en = 1'b1; word.alu = ALU_SUB; word.stb.br_en = 1'b1;
            end
            4'd12: begin
                word.stb.epc_we = 1'b1; word.stb.pc_we = 1'b1;
            end
            default: word.seq = SEQ_FETCH;
        endcase
    end
endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
    import mseq_pkg::*;
#(
    parameter int ENTRIES = NUM_OPS
) (
    input  opc_t   opcode,
    output uaddr_t target
);
    uaddr_t table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign table_q[g] = dispatch_entry(g);
    end

    assign target = table_q[opcode];
endmodule

// File: rtl/mseq_seq.sv
module mseq_seq
    import mseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  seq_e   seq,
    input  uaddr_t disp_addr,
    input  logic   stall,
    output uaddr_t upc
);
    uaddr_t nxt;

    always_comb begin
        case (seq)
            SEQ_NEXT:     nxt = upc + uaddr_t'(1);
            SEQ_DISPATCH: nxt = disp_addr;
            default:      nxt = UA_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         upc <= UA_FETCH;
        else if (!stall) upc <= nxt;
    end
endmodule

// File: rtl/mseq_decode.sv
module mseq_decode
    import mseq_pkg::*;
(
    input  uword_t word,
    input  logic   stall,
    output ctrl_t  ctrl
);
    logic reg_we_raw;

    always_comb begin
        ctrl = '0;
        ctrl.mem_rd    = (word.mem == MEM_IFETCH) || (word.mem == MEM_LOAD);
        ctrl.mem_wr    = (word.mem == MEM_STORE);
        ctrl.mem_iaddr = (word.mem == MEM_IFETCH);
        reg_we_raw      = (word.dst != DST_NONE);
        ctrl.reg_dst_rd = (word.dst == DST_RD);
        ctrl.wb_mem     = (word.dst == DST_MEM);
        ctrl.reg_we     = reg_we_raw && !stall;
        ctrl.stb        = stall ? '0 : word.stb;
        if (word.alu_en)
            ctrl.alu_sel = ALU_N'(1) << word.alu;
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  opcode,
    input  logic             mem_ready,
    output logic [UA_W-1:0]  upc,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             mem_iaddr,
    output logic             ir_we,
    output logic             pc_we,
    output logic             opr_we,
    output logic             res_we,
    output logic             br_en,
    output logic             epc_we,
    output logic             reg_we,
    output logic             reg_dst_rd,
    output logic             wb_mem,
    output logic [ALU_N-1:0] alu_sel
);
    uword_t word;
    uaddr_t disp_addr;
    ctrl_t  ctrl;
    logic   stall;

    assign stall = (word.mem != MEM_IDLE) && !mem_ready;

    mseq_store u_store (.addr(upc), .word(word));

    mseq_dispatch #(.ENTRIES(NUM_OPS)) u_disp (.opcode(opcode), .target(disp_addr));

    mseq_seq u_seq (
        .clk(clk), .rst(rst), .seq(word.seq),
        .disp_addr(disp_addr), .stall(stall), .upc(upc)
    );

    mseq_decode u_dec (.word(word), .stall(stall), .ctrl(ctrl));

    assign mem_rd     = ctrl.mem_rd;
    assign mem_wr     = ctrl.mem_wr;
    assign mem_iaddr  = ctrl.mem_iaddr;
    assign ir_we      = ctrl.stb.ir_we;
    assign pc_we      = ctrl.stb.pc_we;
    assign opr_we     = ctrl.stb.opr_we;
    assign res_we     = ctrl.stb.res_we;
    assign br_en      = ctrl.stb.br_en;
    assign epc_we     = ctrl.stb.epc_we;
    assign reg_we     = ctrl.reg_we;
    assign reg_dst_rd = ctrl.reg_dst_rd;
    assign wb_mem     = ctrl.wb_mem;
    assign alu_sel    = ctrl.alu_sel;
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker
    import mseq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OP_W-1:0]  opcode,
    input logic             mem_ready,
    input logic [UA_W-1:0]  upc,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             mem_iaddr,
    input logic             ir_we,
    input logic             pc_we,
    input logic             reg_we,
    input logic [ALU_N-1:0] alu_sel
);
    logic waiting;
    assign waiting = (mem_rd || mem_wr) && !mem_ready;

    assert_reset_to_fetch_R1: assert property (@(posedge clk)
        rst |=> (upc == UA_FETCH));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_FETCH && mem_ready) |=> (upc == UA_DECODE));

    assert_illegal_dispatch_R5: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_DECODE && opcode >= OP_W'(5)) |=> (upc == UA_ILLEGAL));

    assert_alu_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alu_sel));

    assert_wait_holds_upc_R8: assert property (@(posedge clk) disable iff (rst)
        waiting |=> $stable(upc));

    assert_wait_blocks_strobes_R9: assert property (@(posedge clk) disable iff (rst)
        waiting |-> (!ir_we && !pc_we && !reg_we));

    assert_mem_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && (!mem_iaddr || mem_rd));
endmodule

bind mseq_top mseq_checker u_chk (
    .clk(clk), .rst(rst), .opcode(opcode), .mem_ready(mem_ready), .upc(upc),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_iaddr(mem_iaddr), .ir_we(ir_we),
    .pc_we(pc_we), .reg_we(reg_we), .alu_sel(alu_sel)
);

// File: tb/mseq_top_bench.sv
module mseq_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] opcode = 3'd0;
    logic       mem_ready = 1'b1;
    logic [3:0] upc;
    logic       mem_rd, mem_wr, mem_iaddr, ir_we, pc_we, opr_we, res_we;
    logic       br_en, epc_we, reg_we, reg_dst_rd, wb_mem;
    logic [3:0] alu_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mseq_top u_mseq_top (
        .clk(clk), .rst(rst), .opcode(opcode), .mem_ready(mem_ready), .upc(upc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_iaddr(mem_iaddr), .ir_we(ir_we),
        .pc_we(pc_we), .opr_we(opr_we), .res_we(res_we), .br_en(br_en),
        .epc_we(epc_we), .reg_we(reg_we), .reg_dst_rd(reg_dst_rd),
        .wb_mem(wb_mem), .alu_sel(alu_sel)
    );

    // Bit order: rd wr iaddr ir pc opr res br epc reg_we dst_rd wb_mem alu[3:0]
    function automatic logic [15:0] exp_ctrl(int a, bit waiting);
        logic [15:0] v;
        case (a)
            0:  v = 16'hB801;  // fetch: rd iaddr ir pc ADD (R2)
            1:  v = 16'h0400;  // decode: opr (R3)
            2:  v = 16'h0208;  // res FUNC
            3:  v = 16'h0060;  // reg_we dst rd (R6)
            4:  v = 16'h0201;  // res ADD
            5:  v = 16'h8000;  // data read
            6:  v = 16'h0050;  // reg_we from memory (R6)
            7:  v = 16'h0201;
            8:  v = 16'h4000;  // data write
            9:  v = 16'h0204;  // res OR
            10: v = 16'h0040;  // reg_we dst rt (R6)
            11: v = 16'h0102;  // branch SUB
            12: v = 16'h0880;  // epc pc (R5)
            default: v = 16'h0000;
        endcase
        if (waiting) v = v & ~16'h1FC0;
        return v;
    endfunction

    function automatic int route_len(int op);
        case (op)
            0, 2, 3: return 4;
            1:       return 5;
            default: return 3;
        endcase
    endfunction

    function automatic int route_at(int op, int i);
        int r [5];
        r[0] = 0; r[1] = 1; r[2] = 12; r[3] = 0; r[4] = 0;
        case (op)
            0: begin r[2] = 2;  r[3] = 3;  end
            1: begin r[2] = 4;  r[3] = 5;  r[4] = 6; end
            2: begin r[2] = 7;  r[3] = 8;  end
            3: begin r[2] = 9;  r[3] = 10; end
            4: r[2] = 11;
            default: r[2] = 12;
        endcase
        return r[i];
    endfunction

    function automatic bit is_mem_word(int a);
        return (a == 0) || (a == 5) || (a == 8);
    endfunction

    task automatic check_cycle(int a, bit waiting, string tag);
        logic [15:0] got;
        logic [15:0] want;
        got  = {mem_rd, mem_wr, mem_iaddr, ir_we, pc_we, opr_we, res_we, br_en,
                epc_we, reg_we, reg_dst_rd, wb_mem, alu_sel};
        want = exp_ctrl(a, waiting);
        n_checks++;
        if (upc !== 4'(a) || got !== want) begin
            n_fail++;
            $display("FAIL %s: upc=%0d ctrl=%h expected upc=%0d ctrl=%h",
                     tag, upc, got, a, want);
        end
    endtask

    task automatic run_instr(int op, int waits);
        for (int i = 0; i < route_len(op); i++) begin
            int a;
            string tag;
            a = route_at(op, i);
            if (a == 0)       tag = "R2 R10";
            else if (a == 1)  tag = "R3";
            else if (a == 12) tag = "R5";
            else              tag = "R4 R6 R7 R10";
            if (is_mem_word(a)) begin
                for (int w = 0; w < waits; w++) begin
                    @(negedge clk);
                    opcode = 3'(op); mem_ready = 1'b0;
                    #1 check_cycle(a, 1'b1, "R8 R9");
                end
            end
            @(negedge clk);
            opcode = 3'(op); mem_ready = 1'b1;
            #1 check_cycle(a, 1'b0, tag);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 begin
            n_checks++;
            if (upc !== 4'd0) begin
                n_fail++;
                $display("FAIL R1: upc=%0d expected 0 under reset", upc);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        #1 check_cycle(0, 1'b0, "R1");
        // the cycle above already presented the fetch word with ready high
        for (int i = 1; i < route_len(0); i++) begin
            @(negedge clk);
            #1 check_cycle(route_at(0, i), 1'b0, "R4");
        end

        for (int waits = 0; waits < 3; waits++)
            for (int op = 0; op < 8; op++)
                run_instr(op, waits);

        // reset in the middle of a load routine
        @(negedge clk); opcode = 3'd1; mem_ready = 1'b1; // word 0
        @(negedge clk);                                  // word 1
        @(negedge clk);                                  // word 4
        @(negedge clk); mem_ready = 1'b0;                // word 5, waiting
        #1 check_cycle(5, 1'b1, "R8 R9");
        rst = 1'b1;
        @(negedge clk); rst = 1'b0; mem_ready = 1'b1;
        #1 check_cycle(0, 1'b0, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule